// File: doc/BRIEF.md
# Neighbour-Lookup Cell with Serial Memory Mode

This block is one tile of a homogeneous fabric of identical cells. Each cell has one input bit from each of its four neighbours (north, east, south, west) and drives one output bit back towards each of them. On every rising clock edge the four incoming bits are captured into an input register. The captured 4-bit vector then selects one entry from each of four 16-entry truth tables, one table per output side. The tables and a one-bit mode flag are loaded through a single serial configuration chain, which is clocked while a configuration enable is high.

When the mode flag is set, the truth table that drives the south output becomes a 16-bit serial memory line. Its contents can shift at run time instead of staying fixed. The captured west bit acts as the shift enable and the captured north bit is the serial data fed in. The south output no longer performs a lookup. It presents the oldest bit of that line, which is the bit that will be shifted out next, so that cells placed one after another form a longer delay line or FIFO-like serial store. The cell keeps exactly the same ports in both modes, so any tile can take this role. Which sides act as data and enable is a parameter, and the output side is always the one opposite the data side.

Top module: `lut_mem_cell`

## Requirements
- R1: A synchronous active-high reset clears the input register, all four tables and the mode flag, so every output reads 0 once reset is released.
- R2: The neighbour inputs are captured on the rising clock edge. Output side s then shows entry k of table s, where k is the captured vector and bit i of the vector and of the output bus belongs to side i (0 north, 1 east, 2 south, 3 west).
- R3: While cfg_en is high, the configuration chain moves up by one position per clock and cfg_din enters position 0. The chain is 65 bits long. Position 64 holds the mode flag (1 means memory mode). Table s occupies positions 16*s+15 down to 16*s, and entry k of that table sits at position 16*s+k.
- R4: With the mode flag at 0 and cfg_en low, no input pattern changes any table entry. This includes a high captured west bit.
- R5: In memory mode with cfg_en low, each clock at which the captured west bit is 1 shifts the south table up by one entry. The captured north bit enters entry 0 and the old entry 15 is discarded.
- R6: In memory mode the south output always shows entry 15 of the south table, whatever the captured vector. North, east and west outputs keep performing their lookups.
- R7: In memory mode, a clock at which the captured west bit is 0 leaves every table entry unchanged.
- R8: When cfg_en is high, the configuration shift takes priority over a memory-mode shift on the same clock.
- R9: A data bit that enters the south line appears on the south output after exactly 16 enabled shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration chain shift enable |
| cfg_din | input | 1 | Serial configuration data |
| nbr_in | input | 4 | Neighbour inputs, bit i from side i |
| nbr_out | output | 4 | Outputs towards the neighbours, bit i to side i |

## Verification
The bench targets the one-cycle delay between a neighbour bit arriving and that bit acting as shift enable or data. A design that shifted on the raw inputs would get the order of the memory line wrong by one position. A marker bit is pushed through the line and its arrival is checked after exactly sixteen shifts. A chain one entry too short or too long would expose it early or late. Configuration is loaded while the west input is held high in memory mode, so a design that let the run-time shift override the load ends up with a corrupted south table. Long stretches with the west input high in logic mode catch a shift that was not gated by the mode flag.

// File: rtl/cell_pkg.sv
package cell_pkg;

    localparam int SIDES   = 4;
    localparam int IDX_W   = SIDES;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int CHAIN_W = SIDES * ENTRIES + 1;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    typedef enum logic {
        MODE_LOGIC = 1'b0,
        MODE_MEM   = 1'b1
    } cell_mode_e;

    typedef logic [ENTRIES-1:0] table_t;
    typedef logic [IDX_W-1:0]   nbr_vec_t;

    // Packed so the serial chain position maps directly: mode on top,
    // table i at bits [ENTRIES*i +: ENTRIES].
    typedef struct packed {
        cell_mode_e             mode;
        table_t [SIDES-1:0]     tables;
    } cell_cfg_t;

    function automatic int opposite_side(input int s);
        return (s + 2) % SIDES;
    endfunction

    function automatic logic lut_pick(input table_t t, input nbr_vec_t idx);
        return t[idx];
    endfunction

    function automatic table_t line_push(input table_t t, input logic din);
        return {t[ENTRIES-2:0], din};
    endfunction

endpackage

// File: rtl/cell_in_latch.sv
module cell_in_latch
    import cell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  nbr_vec_t d,
    output nbr_vec_t q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/cell_store.sv
module cell_store
    import cell_pkg::*;
#(
    parameter int DATA_SIDE = 0,
    parameter int EN_SIDE   = 3,
    parameter int TAIL_SIDE = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_en,
    input  logic      cfg_din,
    input  nbr_vec_t  in_q,
    output cell_cfg_t cfg_q
);

    logic [CHAIN_W-1:0] flat_q;
    logic [CHAIN_W-1:0] flat_cfg_nxt;
    cell_cfg_t          cfg_nxt;
    logic               line_shift;

    assign flat_q       = cfg_q;
    assign flat_cfg_nxt = {flat_q[CHAIN_W-2:0], cfg_din};
    assign line_shift   = (cfg_q.mode == MODE_MEM) && in_q[EN_SIDE];

    always_comb begin
        cfg_nxt = cfg_q;
        if (cfg_en) begin
            cfg_nxt = cell_cfg_t'(flat_cfg_nxt);
        end else if (line_shift) begin
            cfg_nxt.tables[TAIL_SIDE] =
                line_push(cfg_q.tables[TAIL_SIDE], in_q[DATA_SIDE]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_nxt;
    end

endmodule

// File: rtl/cell_out_mux.sv
module cell_out_mux
    import cell_pkg::*;
#(
    parameter int TAIL_SIDE = 2
) (
    input  nbr_vec_t          in_q,
    input  cell_cfg_t         cfg_q,
    output logic [SIDES-1:0]  out
);

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        if (g == TAIL_SIDE) begin : g_tail
            assign out[g] = (cfg_q.mode == MODE_MEM)
                          ? cfg_q.tables[g][ENTRIES-1]
                          : lut_pick(cfg_q.tables[g], in_q);
        end else begin : g_plain
            assign out[g] = lut_pick(cfg_q.tables[g], in_q);
        end
    end

endmodule

// File: rtl/lut_mem_cell.sv
module lut_mem_cell
    import cell_pkg::*;
#(
    parameter int DATA_SIDE = 0,
    parameter int EN_SIDE   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_en,
    input  logic       cfg_din,
    input  logic [3:0] nbr_in,
    output logic [3:0] nbr_out
);

    localparam int TAIL_SIDE = opposite_side(DATA_SIDE);

    nbr_vec_t  in_q;
    cell_cfg_t cfg_q;

    cell_in_latch u_latch (
        .clk (clk),
        .rst (rst),
        .d   (nbr_in),
        .q   (in_q)
    );

    cell_store #(
        .DATA_SIDE (DATA_SIDE),
        .EN_SIDE   (EN_SIDE),
        .TAIL_SIDE (TAIL_SIDE)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .in_q    (in_q),
        .cfg_q   (cfg_q)
    );

    cell_out_mux #(
        .TAIL_SIDE (TAIL_SIDE)
    ) u_mux (
        .in_q  (in_q),
        .cfg_q (cfg_q),
        .out   (nbr_out)
    );

endmodule

// File: rtl/lut_mem_cell_chk.sv
module lut_mem_cell_chk
    import cell_pkg::*;
#(
    parameter int DATA_SIDE = 0,
    parameter int EN_SIDE   = 3,
    parameter int TAIL_SIDE = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_en,
    input logic               cfg_din,
    input logic [3:0]         nbr_in,
    input logic [3:0]         nbr_out,
    input logic [IDX_W-1:0]   in_q,
    input logic [CHAIN_W-1:0] cfg_q
);

    logic               mode_bit;
    logic [ENTRIES-1:0] tail_tbl;

    assign mode_bit = cfg_q[CHAIN_W-1];
    assign tail_tbl = cfg_q[TAIL_SIDE*ENTRIES +: ENTRIES];

    // R1: outputs are zero right after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> nbr_out == 4'b0000);

    // R2: input register captures the neighbour bits
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> in_q == $past(nbr_in));

    // R3 and R8: configuration shift wins over everything
    a_r8_cfg_priority: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_q == {$past(cfg_q[CHAIN_W-2:0]), $past(cfg_din)});

    // R4: logic mode keeps tables frozen
    a_r4_logic_frozen: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !mode_bit) |=> $stable(cfg_q));

    // R7: memory mode without enable holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !in_q[EN_SIDE]) |=> $stable(cfg_q));

    // R5: enabled shift moves the line by one and takes the data bit
    a_r5_line_shift: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && mode_bit && in_q[EN_SIDE]) |=>
            tail_tbl == {$past(tail_tbl[ENTRIES-2:0]), $past(in_q[DATA_SIDE])});

    // R6: tail side output shows the oldest bit in memory mode
    a_r6_tail_out: assert property (@(posedge clk) disable iff (rst)
        mode_bit |-> nbr_out[TAIL_SIDE] == tail_tbl[ENTRIES-1]);

endmodule

bind lut_mem_cell lut_mem_cell_chk #(
    .DATA_SIDE (DATA_SIDE),
    .EN_SIDE   (EN_SIDE),
    .TAIL_SIDE (TAIL_SIDE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .nbr_in  (nbr_in),
    .nbr_out (nbr_out),
    .in_q    (in_q),
    .cfg_q   (cfg_q)
);

// File: tb/lut_mem_cell_test.sv
`timescale 1ns/1ps
module lut_mem_cell_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] nbr_in = 4'h0;
    logic [3:0] nbr_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state derived from the requirements
    logic [64:0] m_cfg = '0;
    logic [3:0]  m_inq = '0;

    always #2.5 clk = ~clk;

    lut_mem_cell uut (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .nbr_in  (nbr_in),
        .nbr_out (nbr_out)
    );

    function automatic logic [3:0] expect_out();
        logic [3:0] e;
        for (int s = 0; s < 4; s++)
            e[s] = m_cfg[s*16 + int'(m_inq)];
        if (m_cfg[64]) e[2] = m_cfg[47];
        return e;
    endfunction

    task automatic chk(input string tag, input logic [3:0] exp_v);
        checks++;
        if (nbr_out !== exp_v) begin
            errors++;
            $display("FAIL %s: nbr_out=%b expected=%b at %0t", tag, nbr_out, exp_v, $time);
        end
    endtask

    // called at a falling edge; drives, advances one clock, updates model
    task automatic step(input logic [3:0] nin, input logic ce, input logic cd);
        nbr_in  = nin;
        cfg_en  = ce;
        cfg_din = cd;
        @(posedge clk);
        if (ce) m_cfg = {m_cfg[63:0], cd};
        else if (m_cfg[64] && m_inq[3]) m_cfg[47:32] = {m_cfg[46:32], m_inq[0]};
        m_inq = nin;
        @(negedge clk);
    endtask

    task automatic step_chk(input string tag, input logic [3:0] nin);
        step(nin, 1'b0, 1'b0);
        chk(tag, expect_out());
    endtask

    task automatic load(input logic [64:0] img, input logic [3:0] hold_in);
        for (int i = 64; i >= 0; i--) step(hold_in, 1'b1, img[i]);
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 16; k++) begin
            step(4'(k), 1'b0, 1'b0);
            // index k selects entry k of each table
            checks++;
            if (m_cfg[64] == 1'b0) begin : plain
                logic [3:0] e;
                for (int s = 0; s < 4; s++) e[s] = m_cfg[s*16 + k];
                if (nbr_out !== e) begin
                    errors++;
                    $display("FAIL %s: idx=%0d nbr_out=%b expected=%b", tag, k, nbr_out, e);
                end
            end else if (nbr_out !== expect_out()) begin
                errors++;
                $display("FAIL %s: idx=%0d nbr_out=%b expected=%b", tag, k, nbr_out, expect_out());
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [64:0] img;
        logic [15:0] pattern;
        void'($urandom(32'd1357));

        // R1: reset
        rst = 1'b1;
        repeat (3) @(negedge clk);
        nbr_in = 4'hF;
        @(negedge clk);
        rst = 1'b0;
        nbr_in = 4'h0;
        chk("R1", 4'b0000);
        step_chk("R1", 4'h0);

        // R3: load a random logic-mode image, verify every entry
        img = {1'b0, $urandom(), $urandom()};
        load(img, 4'h0);
        sweep("R3");
        if (m_cfg !== img) begin
            errors++;
            $display("FAIL R3: model image mismatch %h expected %h", m_cfg, img);
        end

        // R2: random neighbour patterns
        for (int n = 0; n < 40; n++) step_chk("R2", 4'($urandom()));

        // R4: logic mode with west held high
        for (int n = 0; n < 24; n++) step_chk("R4", 4'($urandom()) | 4'h8);
        sweep("R4");

        // memory mode image with random tables
        img = {1'b1, $urandom(), $urandom()};
        load(img, 4'h0);

        // R6 and R7: west low, lookups on N/E/W, tail on S
        for (int n = 0; n < 32; n++) step_chk("R6", 4'($urandom()) & 4'h7);
        for (int n = 0; n < 8; n++)  step_chk("R7", 4'($urandom()) & 4'h7);

        // R5: write a pattern, then read it back through the tail
        pattern = 16'($urandom());
        for (int n = 0; n < 16; n++) step_chk("R5", {1'b1, 2'($urandom()), pattern[n]});
        for (int n = 0; n < 6; n++)  step_chk("R7", 4'($urandom()) & 4'h7);
        for (int n = 0; n < 16; n++) begin
            step_chk("R5", {1'b1, 3'($urandom()) & 3'b110});
        end

        // R9: a single marker after zeros needs exactly 16 shifts
        for (int n = 0; n < 18; n++) step_chk("R9", 4'h8);
        step_chk("R9", 4'h9);
        for (int n = 1; n <= 18; n++) begin
            step(4'h8, 1'b0, 1'b0);
            checks++;
            // marker captured one clock late, shifted in one clock after that;
            // it reaches entry 15 after 16 shifts in total
            if (nbr_out[2] !== (n == 16)) begin
                errors++;
                $display("FAIL R9: after %0d steps tail=%b expected=%b", n, nbr_out[2], (n == 16));
            end
        end

        // R8: load while memory mode is active and west held high
        img = {1'b0, $urandom(), $urandom()};
        load(img, 4'h9);
        checks++;
        if (m_cfg !== img) begin
            errors++;
            $display("FAIL R8: model image %h expected %h", m_cfg, img);
        end
        sweep("R8");

        // mixed random run, memory mode, occasional reload bits
        img = {1'b1, $urandom(), $urandom()};
        load(img, 4'($urandom()));
        for (int n = 0; n < 300; n++) begin
            if (($urandom() % 16) == 0) begin
                step(4'($urandom()), 1'b1, 1'($urandom()));
                chk("R8", expect_out());
            end else begin
                step_chk("R5", 4'($urandom()));
            end
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule